// File: doc/BRIEF.md
# Indirect-Addressed PHY Management Sequencer

This block is a management-port master for PHY registers that use indirect addressing (the clause-45 frame structure). A host supplies a 16-bit register address, a 5-bit device type, a 5-bit port address and a read/write choice, and then raises a start strobe. The block sets its busy flag and runs two serialized frames on the MDC/MDIO pins. The first frame is an address frame that carries the register address. The second frame is a read or a write to the same port and device type. The second frame is launched only after the first frame completes.

Write data is placed in the low half of a 32-bit data register before the access is started. The data captured by a read lands in the high half of the same register. MDC runs only while a frame is on the wire, and its frequency is the system clock divided by a parameter.

Each frame has its own cycle-count watchdog. When a frame overruns that count, the access is abandoned with an error pulse, and any frame still pending is not sent. A normal finish gives a single-cycle done pulse, and the busy flag falls in the same cycle.

Top module: `mdio45_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mdc_o and mdio_oe_o are 0 and data_reg_o is 0.
- R2: A start strobe taken while idle first sends an address frame, most significant bit first: 32 ones, start bits 00, opcode 00, 5-bit port address, 5-bit device type, turnaround 10, 16-bit register address. MDIO changes only while MDC is low.
- R3: For a write, the second frame carries opcode 01, the same port address and device type, turnaround 10, and data_reg_o[15:0] as its 16-bit field.
- R4: For a read, the second frame carries opcode 11. The block releases MDIO (mdio_oe_o=0) for the two turnaround bits and the 16 data bits. It samples mdio_i at the MDC rising edge of each data bit, most significant first. The result is stored in data_reg_o[31:16], and data_reg_o[15:0] is kept.
- R5: The second frame begins only after the address frame has ended. busy_o is 1 from the cycle after the start strobe until the access ends. done_o is a one-cycle pulse, given in the cycle where busy_o falls.
- R6: MDC has a period of MDC_DIV system clocks at 50% duty cycle while a frame runs, and it stays low while no frame runs.
- R7: If a frame runs for TIMEOUT_CYC cycles without finishing, the frame is stopped. err_o pulses for one cycle, busy_o falls, no second frame is sent and done_o is not pulsed. done_o and err_o are never high together.
- R8: While busy_o is 1, cmd_start and wdata_we are ignored. The frames in flight and data_reg_o[15:0] are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe; taken only while idle |
| cmd_rd | input | 1 | 1 = read access, 0 = write access |
| cmd_prtad | input | 5 | Port address of the target PHY |
| cmd_devad | input | 5 | Device type within the PHY |
| cmd_regaddr | input | 16 | Register address sent in the address frame |
| wdata_we | input | 1 | Loads wdata into data_reg_o[15:0] while idle |
| wdata | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse at the normal end of an access |
| err_o | output | 1 | One-cycle pulse when a frame times out |
| data_reg_o | output | 32 | [31:16] last read result, [15:0] write data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume three things about the inputs. The start strobe and the command fields hold for at least one clock. mdio_i changes only while MDC is low. MDC_DIV is even and at least 2. The bench PHY model drives mdio_i a moment after each MDC falling edge, and it drives only during the turnaround and data bits of a read frame. Commands are presented at clock falling edges and last exactly one cycle. Strobes issued during a busy access deliberately break the idle-only rule, to show that the block ignores them. The timeout path is exercised on a second instance whose watchdog is shorter than one frame.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int PRE_BITS   = 32;
  localparam int REL_IDX    = 46;  // first turnaround bit
  localparam int DATA_IDX   = 48;  // first data bit

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_AGO,
    S_ARUN,
    S_DGO,
    S_DRUN
  } seq_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mdio_op_e       op,
    input logic [4:0]     prt,
    input logic [4:0]     dev,
    input logic [DATA_BITS-1:0] payload
  );
    return {{PRE_BITS{1'b1}}, 2'b00, op, prt, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio45_mdc.sv
module mdio45_mdc #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap      = en && (cnt_q == CMAX);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap &&  mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio45_frame.sv
module mdio45_frame
  import mdio45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  abort,
  input  logic                  rd_frame,
  input  logic [FRAME_BITS-1:0] word,
  input  logic                  mdc_lvl,
  input  logic                  mdc_rise,
  input  logic                  mdc_fall,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_BITS-1:0]  rdata
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] REL  = IW'(REL_IDX);
  localparam logic [IW-1:0] DIX  = IW'(DATA_IDX);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  act_q, act_d;
  logic                  rd_q, rd_d;
  logic                  done_q, done_d;
  logic [DATA_BITS-1:0]  rdat_q, rdat_d;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    act_d  = act_q;
    rd_d   = rd_q;
    rdat_d = rdat_q;
    done_d = 1'b0;
    if (start) begin
      sh_d  = word;
      idx_d = '0;
      act_d = 1'b1;
      rd_d  = rd_frame;
    end else if (abort) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (mdc_rise && rd_q && (idx_q >= DIX)) begin
        rdat_d = {rdat_q[DATA_BITS-2:0], mdio_i};
      end
      if (mdc_fall) begin
        if (idx_q == LAST) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      rdat_q <= rdat_d;
    end
  end

  assign active  = act_q;
  assign done    = done_q;
  assign rdata   = rdat_q;
  assign mdio_o  = act_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = act_q && !(rd_q && (idx_q >= REL));

  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_lvl && act_q) |-> $stable(mdio_o)) else $error("mdio moved while mdc high"); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(idx_q) == LAST)) else $error("frame ended early"); // R2
endmodule

// File: rtl/mdio45_timer.sv
module mdio45_timer #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == TLIM);

  always_comb begin
    cnt_d = cnt_q;
    if (arm)             cnt_d = '0;
    else if (run && !expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio45_seq.sv
module mdio45_seq
  import mdio45_pkg::*;
#(
  parameter int MDC_DIV     = 4,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_rd,
  input  logic [4:0]  cmd_prtad,
  input  logic [4:0]  cmd_devad,
  input  logic [15:0] cmd_regaddr,
  input  logic        wdata_we,
  input  logic [15:0] wdata,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] data_reg_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int HALF = MDC_DIV / 2;

  seq_state_e state_q, state_d;
  logic        lat_rd_q, lat_rd_d;
  logic [4:0]  lat_prt_q, lat_prt_d;
  logic [4:0]  lat_dev_q, lat_dev_d;
  logic [15:0] lat_addr_q, lat_addr_d;
  logic [15:0] data_lo_q, data_lo_d;
  logic [15:0] data_hi_q, data_hi_d;
  logic        done_q, done_d;
  logic        err_q, err_d;

  logic                  fr_start, fr_abort, fr_rd, fr_active, fr_done;
  logic [FRAME_BITS-1:0] fr_word;
  logic [DATA_BITS-1:0]  fr_rdata;
  logic                  mdc_lvl, mdc_rise, mdc_fall;
  logic                  tmo;
  logic                  busy_q;

  assign busy_q = (state_q != S_IDLE);

  // frame launch and word selection
  always_comb begin
    fr_start = (state_q == S_AGO) || (state_q == S_DGO);
    fr_rd    = (state_q == S_DGO) && lat_rd_q;
    fr_abort = tmo;
    if (state_q == S_DGO) begin
      fr_word = build_frame(lat_rd_q ? OP_READ : OP_WRITE, lat_prt_q, lat_dev_q,
                            lat_rd_q ? 16'hFFFF : data_lo_q);
    end else begin
      fr_word = build_frame(OP_ADDR, lat_prt_q, lat_dev_q, lat_addr_q);
    end
  end

  // next state
  always_comb begin
    state_d    = state_q;
    lat_rd_d   = lat_rd_q;
    lat_prt_d  = lat_prt_q;
    lat_dev_d  = lat_dev_q;
    lat_addr_d = lat_addr_q;
    data_lo_d  = data_lo_q;
    data_hi_d  = data_hi_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (wdata_we) data_lo_d = wdata;
        if (cmd_start) begin
          lat_rd_d   = cmd_rd;
          lat_prt_d  = cmd_prtad;
          lat_dev_d  = cmd_devad;
          lat_addr_d = cmd_regaddr;
          state_d    = S_AGO;
        end
      end
      S_AGO: state_d = S_ARUN;
      S_ARUN: begin
        if (tmo) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else if (fr_done) begin
          state_d = S_DGO;
        end
      end
      S_DGO: state_d = S_DRUN;
      S_DRUN: begin
        if (tmo) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else if (fr_done) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
          if (lat_rd_q) data_hi_d = fr_rdata;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      lat_rd_q   <= 1'b0;
      lat_prt_q  <= '0;
      lat_dev_q  <= '0;
      lat_addr_q <= '0;
      data_lo_q  <= '0;
      data_hi_q  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      lat_rd_q   <= lat_rd_d;
      lat_prt_q  <= lat_prt_d;
      lat_dev_q  <= lat_dev_d;
      lat_addr_q <= lat_addr_d;
      data_lo_q  <= data_lo_d;
      data_hi_q  <= data_hi_d;
      done_q     <= done_d;
      err_q      <= err_d;
    end
  end

  mdio45_mdc #(.HALF(HALF)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (fr_active),
    .mdc       (mdc_lvl),
    .rise_tick (mdc_rise),
    .fall_tick (mdc_fall)
  );

  mdio45_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fr_start),
    .abort    (fr_abort),
    .rd_frame (fr_rd),
    .word     (fr_word),
    .mdc_lvl  (mdc_lvl),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_i   (mdio_i),
    .active   (fr_active),
    .done     (fr_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe_o),
    .rdata    (fr_rdata)
  );

  mdio45_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (fr_start),
    .run    (fr_active),
    .expire (tmo)
  );

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign data_reg_o = {data_hi_q, data_lo_q};
  assign mdc_o      = mdc_lvl;

  AST_END_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q || err_q)) else $error("busy fell without status"); // R5

  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DGO) |-> $past(fr_done)) else $error("data frame before address end"); // R5

  AST_NO_DONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)) else $error("done and err together"); // R7

  AST_TMO_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !fr_active) else $error("frame kept running after timeout"); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_start) |=> ($stable(lat_addr_q) && $stable(lat_prt_q) &&
                               $stable(lat_dev_q) && $stable(lat_rd_q)))
    else $error("start taken while busy"); // R8

  AST_WDATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(data_lo_q)) else $error("write data changed while busy"); // R8
endmodule

// File: tb/mdio45_seq_tb.sv
module mdio45_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        cmd_start, cmd_rd, wdata_we;
  logic [4:0]  cmd_prtad, cmd_devad;
  logic [15:0] cmd_regaddr, wdata;
  logic        busy, done, err, mdc, mdo, mdoe;
  logic [31:0] dreg;
  logic        mdi;
  logic        busy_t, done_t, err_t, mdc_t, mdo_t, mdoe_t;
  logic [31:0] dreg_t;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] exp_frames[$];
  logic [31:0] exp_res[$];
  logic [15:0] exp_low = 16'h0000;
  logic [15:0] exp_hi  = 16'h0000;

  int          pbit = 0;
  logic [63:0] cap = '0;
  logic [1:0]  cur_op = 2'b00;
  logic [4:0]  cur_prt = '0, cur_dev = '0;
  logic [15:0] phy_addr = '0;
  int          done_t_cnt = 0;
  bit          prev_done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  mdio45_seq #(.MDC_DIV(4), .TIMEOUT_CYC(1024)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rd(cmd_rd),
    .cmd_prtad(cmd_prtad), .cmd_devad(cmd_devad), .cmd_regaddr(cmd_regaddr),
    .wdata_we(wdata_we), .wdata(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .data_reg_o(dreg), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi));

  mdio45_seq #(.MDC_DIV(4), .TIMEOUT_CYC(100)) u_dut_tmo (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rd(cmd_rd),
    .cmd_prtad(cmd_prtad), .cmd_devad(cmd_devad), .cmd_regaddr(cmd_regaddr),
    .wdata_we(1'b0), .wdata(wdata), .busy_o(busy_t), .done_o(done_t), .err_o(err_t),
    .data_reg_o(dreg_t), .mdc_o(mdc_t), .mdio_o(mdo_t), .mdio_oe_o(mdoe_t), .mdio_i(1'b1));

  function automatic logic [15:0] phy_val(input logic [15:0] a, input logic [4:0] d,
                                          input logic [4:0] p);
    return a ^ {p, d, 6'h2B};
  endfunction

  function automatic logic [63:0] mk_frame(input logic [1:0] op, input logic [4:0] p,
      input logic [4:0] d, input logic [1:0] ta, input logic [15:0] f);
    return {32'hFFFF_FFFF, 2'b00, op, p, d, ta, f};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // PHY model: capture bits on MDC rising edges, 64 per frame
  always @(posedge mdc) begin
    #1;
    cap = {cap[62:0], (mdoe ? mdo : 1'b1)};
    pbit++;
    if (pbit == 36) cur_op = cap[1:0];
    if (pbit == 46) begin cur_prt = cap[9:5]; cur_dev = cap[4:0]; end
    if (pbit == 64) begin
      if (exp_frames.size() == 0) begin
        chk("R8 unexpected frame", cap, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_frames.pop_front();
        case (e[29:28])
          2'b00:   chk("R2 address frame", cap, e);
          2'b01:   chk("R3 write frame", cap, e);
          default: chk("R4 read frame", cap, e);
        endcase
      end
      if (cur_op == 2'b00) phy_addr = cap[15:0];
      pbit = 0;
      cur_op = 2'b00;
    end
  end

  // PHY model: drive read turnaround and data after MDC falling edges
  always @(negedge mdc) begin
    #1;
    if (cur_op == 2'b11 && pbit == 47)
      mdi = 1'b0;
    else if (cur_op == 2'b11 && pbit >= 48 && pbit <= 63)
      mdi = phy_val(phy_addr, cur_dev, cur_prt)[63 - pbit];
    else
      mdi = 1'b1;
  end

  // result monitor for the main instance
  always @(negedge clk) begin
    if (rst_n) begin
      if (err) chk("R7 no error on main instance", {63'b0, err}, 64'h0);
      if (done) begin
        if (prev_done) chk("R5 done single cycle", 64'h1, 64'h0);
        chk("R5 busy low with done", {63'b0, busy}, 64'h0);
        if (exp_res.size() == 0) chk("R5 unexpected done", 64'h1, 64'h0);
        else chk("R4 data register after access", {32'b0, dreg}, {32'b0, exp_res.pop_front()});
      end
      prev_done = done;
      if (done_t) done_t_cnt++;
    end
  end

  task automatic load_wdata(input logic [15:0] v, input bit ignored);
    @(negedge clk);
    wdata_we = 1'b1; wdata = v;
    @(negedge clk);
    wdata_we = 1'b0;
    if (!ignored) exp_low = v;
  endtask

  task automatic do_access(input logic rd, input logic [4:0] p, input logic [4:0] d,
                           input logic [15:0] a);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_frames.push_back(mk_frame(2'b00, p, d, 2'b10, a));
    if (rd) begin
      exp_frames.push_back(mk_frame(2'b11, p, d, 2'b11, 16'hFFFF));
      exp_hi = phy_val(a, d, p);
    end else begin
      exp_frames.push_back(mk_frame(2'b01, p, d, 2'b10, exp_low));
    end
    exp_res.push_back({exp_hi, exp_low});
    cmd_rd = rd; cmd_prtad = p; cmd_devad = d; cmd_regaddr = a; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk("R5 busy after start", {63'b0, busy}, 64'h1);
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmd_start = 0; cmd_rd = 0; wdata_we = 0;
    cmd_prtad = 0; cmd_devad = 0; cmd_regaddr = 0; wdata = 0; mdi = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'b0, busy}, 64'h0);
    chk("R1 done/err", {62'b0, done, err}, 64'h0);
    chk("R1 mdc/oe", {62'b0, mdc, mdoe}, 64'h0);
    chk("R1 data_reg", {32'b0, dreg}, 64'h0);

    // writes then reads with different patterns
    load_wdata(16'hA55A, 0);
    do_access(1'b0, 5'd3, 5'd1, 16'h1234);
    // R6 MDC period and duty during a frame
    begin
      int hi = 0, lo = 0;
      @(negedge clk);
      while (!mdc) @(negedge clk);
      while (mdc) begin hi++; @(negedge clk); end
      while (!mdc) begin lo++; @(negedge clk); end
      chk("R6 mdc high clocks", 64'(hi), 64'd2);
      chk("R6 mdc low clocks", 64'(lo), 64'd2);
    end
    wait_idle();
    chk("R6 mdc low when idle", {63'b0, mdc}, 64'h0);
    chk("R5 no status when idle", {62'b0, done, err}, 64'h0);

    do_access(1'b1, 5'd31, 5'd7, 16'hFFFF);
    wait_idle();
    chk("R4 low field kept", {48'b0, dreg[15:0]}, {48'b0, exp_low});
    do_access(1'b1, 5'd0, 5'd0, 16'h0000);
    wait_idle();
    load_wdata(16'h0001, 0);
    do_access(1'b0, 5'd16, 5'd31, 16'h8000);
    wait_idle();
    do_access(1'b1, 5'd21, 5'd30, 16'hC3A5);
    // back-to-back without a gap
    do_access(1'b1, 5'd10, 5'd5, 16'h5A00);
    wait_idle();

    // R8 strobes while busy are ignored
    load_wdata(16'h7E81, 0);
    do_access(1'b0, 5'd9, 5'd2, 16'h0F0F);
    repeat (40) @(negedge clk);
    cmd_rd = 1'b1; cmd_prtad = 5'd1; cmd_devad = 5'd1; cmd_regaddr = 16'hBEEF;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    load_wdata(16'hDEAD, 1);
    wait_idle();
    chk("R8 write data unchanged", {48'b0, dreg[15:0]}, {48'b0, exp_low});
    repeat (600) @(negedge clk);
    chk("R8 no extra frames pending", 64'(exp_frames.size()), 64'd0);
    chk("R5 all results seen", 64'(exp_res.size()), 64'd0);
    chk("R8 still idle", {63'b0, busy}, 64'h0);

    // R7 timeout on the short-watchdog instance (run alone while main is idle)
    begin
      int n = 0, pulses = 0;
      bit seen = 0;
      cmd_rd = 1'b1; cmd_prtad = 5'd4; cmd_devad = 5'd4; cmd_regaddr = 16'h4444;
      // keep the main instance out of it: it is idle, so it would take the strobe;
      // expect its frames and result as a normal read
      exp_frames.push_back(mk_frame(2'b00, 5'd4, 5'd4, 2'b10, 16'h4444));
      exp_frames.push_back(mk_frame(2'b11, 5'd4, 5'd4, 2'b11, 16'hFFFF));
      exp_hi = phy_val(16'h4444, 5'd4, 5'd4);
      exp_res.push_back({exp_hi, exp_low});
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk("R7 busy after start", {63'b0, busy_t}, 64'h1);
      while (n < 300 && !seen) begin
        if (err_t) seen = 1;
        else begin n++; @(negedge clk); end
      end
      chk("R7 error pulse seen", {63'b0, seen}, 64'h1);
      chk("R7 busy cleared with error", {63'b0, busy_t}, 64'h0);
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (err_t) pulses++;
        if (mdoe_t || mdc_t) begin
          chk("R7 no second frame", {62'b0, mdoe_t, mdc_t}, 64'h0);
          break;
        end
      end
      chk("R7 single error pulse", 64'(pulses), 64'd0);
      chk("R7 no done on timeout", 64'(done_t_cnt), 64'd0);
      chk("R7 idle after timeout", {63'b0, busy_t}, 64'h0);
    end
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R4 timeout-run read result consumed", 64'(exp_res.size()), 64'd0);
    summary();
  end
endmodule